// File: doc/BRIEF.md
# Memory-Mapped Event Counter Group

This block holds a parameterised group of event counters behind a 32-bit word-addressed register bus. Each cycle a set of event lanes presents pulses, each lane carrying an event code and a stream identifier. A counter adds one for every lane in that cycle whose code equals the counter's programmed code and whose stream identifier passes the counter's stream filter. Code 0 counts clock cycles instead of lane pulses. Code 0xFFFF is reserved as a stop code that never counts.

Counting runs only when the group-wide run bit and the counter's own enable bit are both set. Counter, interrupt-enable and overflow bitmaps are updated by separate set and clear write addresses, so software never needs a read-modify-write. The stream filter works either per counter or, when the group is built in shared-filter mode, from counter 0's filter settings for every counter.

When a counter carries out of its most significant bit it latches an overflow bit. The interrupt line is high while an overflow bit whose interrupt enable is set is pending and the interrupt control bit is on. Counters are writable, so software can preload a value close to full scale.

A two-state read machine returns data. The states are `BUS_IDLE` and `BUS_RESP`. A read request moves the machine to `BUS_RESP` from either state. Any other cycle returns it to `BUS_IDLE`.

Top module: `evcnt_group`

## Requirements
- R1: After reset all counters, enable bitmaps and overflow bits read 0. Every stream-match register reads all ones. The configuration word at byte 0xE00 reads NUM_CTR-1 in bits [5:0], CTR_W-1 in bits [13:8] and the shared-filter flag in bit 23.
- R2: Writing ones to 0xC00 sets counter-enable bits and writing ones to 0xC20 clears them; 0xC40/0xC60 do the same for interrupt enables. Bit n touches only counter n, and either address of a pair reads the current bitmap.
- R3: A counter changes only when the run bit (0xE04 bit 0) and its own enable bit are both set. It then adds the number of lanes in that cycle whose code and stream identifier qualify.
- R4: With span bit 29 of the event-type register clear, a lane's stream identifier must equal the stream-match register exactly.
- R5: With the span bit set, the lowest zero bit of the stream-match register and all bits below it are ignored, and the remaining bits must be equal. An all-ones pattern matches any identifier. The type register reads back its code in [15:0] and span in bit 29.
- R6: In shared-filter mode, every counter uses counter 0's span and stream-match value, combined with its own event code.
- R7: A counter whose code is 0xFFFF never counts, even when lanes carry code 0xFFFF.
- R8: A counter whose code is 0 adds one on every clock edge at which it is enabled, regardless of the lanes.
- R9: Counters sit at byte n*4 (n*8 with two words when CTR_W exceeds 32) and are writable. A write in the same cycle as a qualified event stores the written value.
- R10: A carry out of the counter's MSB sets its overflow bit. The overflow bitmap reads at 0xCC0, writing ones there sets bits, and writing ones to 0xC80 clears them.
- R11: `irq` is high exactly while interrupt control (0xE50 bit 0) is set and some overflow bit with its interrupt enable set is pending.
- R12: `bus_rvalid` is high, with the read word on `bus_rdata`, in the cycle after a read request, and low after any cycle without one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Bus access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address, low two bits ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response strobe |
| ev_valid | input | LANES | Per-lane event pulse |
| ev_code | input | LANES*16 | Per-lane event code, lane 0 in the low bits |
| ev_sid | input | LANES*SID_W | Per-lane stream identifier |
| irq | output | 1 | Level interrupt for enabled overflows |

## Verification
A corrupted enable or filter state appears at the ports as a counter value off by a whole number of lanes. It can be read back on the bus in the cycle after the read request. A shared-filter routing fault shows as two identically programmed groups, one built per-counter and one shared, disagreeing on a counter other than counter 0. A broken carry or overflow path shows on `irq` one cycle after the wrapping event edge. It also shows as a counter that fails to read zero after wrapping from 0xFFFFFFFE with two lanes.

// File: rtl/evcnt_pkg.sv
package evcnt_pkg;
    localparam int CODE_W = 16;
    localparam logic [CODE_W-1:0] CODE_CYCLES = 16'h0000;
    localparam logic [CODE_W-1:0] CODE_STOP   = 16'hFFFF;
    localparam int SPAN_BIT = 29;

    // word offsets (byte address >> 2)
    localparam int WA_TYP  = 'h100;
    localparam int WA_SMR  = 'h280;
    localparam int WA_CENS = 'h300;
    localparam int WA_CENC = 'h308;
    localparam int WA_IENS = 'h310;
    localparam int WA_IENC = 'h318;
    localparam int WA_OVC  = 'h320;
    localparam int WA_OVS  = 'h330;
    localparam int WA_CFG  = 'h380;
    localparam int WA_CTL  = 'h381;
    localparam int WA_ICT  = 'h394;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_e;
endpackage

// File: rtl/evcnt_sid_match.sv
module evcnt_sid_match #(
    parameter int SID_W = 16
) (
    input  logic             span,
    input  logic [SID_W-1:0] pattern,
    input  logic [SID_W-1:0] sid,
    output logic             hit
);
    logic [SID_W-1:0] dont_care;
    logic [SID_W-1:0] care;

    always_comb begin
        // lowest zero bit of the pattern and everything below it
        dont_care = pattern ^ (pattern + SID_W'(1));
        care      = span ? ~dont_care : {SID_W{1'b1}};
        hit       = ((sid ^ pattern) & care) == '0;
    end
endmodule

// File: rtl/evcnt_slice.sv
module evcnt_slice
    import evcnt_pkg::*;
#(
    parameter int CTR_W = 32,
    parameter int LANES = 2,
    parameter int SID_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    run,
    input  logic                    wr_lo,
    input  logic                    wr_hi,
    input  logic                    wr_typ,
    input  logic                    wr_smr,
    input  logic [31:0]             wdata,
    input  logic                    eff_span,
    input  logic [SID_W-1:0]        eff_smr,
    input  logic [LANES-1:0]        ev_valid,
    input  logic [LANES*CODE_W-1:0] ev_code,
    input  logic [LANES*SID_W-1:0]  ev_sid,
    output logic [CTR_W-1:0]        cnt_q,
    output logic [CODE_W-1:0]       code_q,
    output logic                    span_q,
    output logic [SID_W-1:0]        smr_q,
    output logic                    wrap
);
    localparam int INC_W = $clog2(LANES + 2);
    localparam int LO_W  = (CTR_W > 32) ? 32 : CTR_W;

    logic [LANES-1:0] sid_hit;
    logic [INC_W-1:0] inc;
    logic [CTR_W:0]   sum;
    logic [CTR_W-1:0] wr_val;
    logic [CTR_W-1:0] cnt_d;
    logic             any_wr;
    logic             unused_slice;

    assign unused_slice = ^{wdata[31:30], wdata[28:16], wr_hi};
    assign any_wr = wr_lo | wr_hi;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        evcnt_sid_match #(.SID_W(SID_W)) u_match (
            .span    (eff_span),
            .pattern (eff_smr),
            .sid     (ev_sid[l*SID_W +: SID_W]),
            .hit     (sid_hit[l])
        );
    end

    if (CTR_W > 32) begin : g_wide
        always_comb begin
            wr_val = cnt_q;
            if (wr_lo) wr_val[31:0] = wdata;
            if (wr_hi) wr_val[CTR_W-1:32] = wdata[CTR_W-33:0];
        end
    end else begin : g_narrow
        assign wr_val = wdata[CTR_W-1:0];
    end

    always_comb begin
        inc = '0;
        if (code_q == CODE_CYCLES) begin
            inc = INC_W'(1);
        end else if (code_q != CODE_STOP) begin
            for (int l = 0; l < LANES; l++) begin
                if (ev_valid[l] && sid_hit[l] &&
                    ev_code[l*CODE_W +: CODE_W] == code_q)
                    inc = inc + INC_W'(1);
            end
        end
        sum = {1'b0, cnt_q} + (CTR_W+1)'(inc);
        if (any_wr)   cnt_d = wr_val;
        else if (run) cnt_d = sum[CTR_W-1:0];
        else          cnt_d = cnt_q;
        wrap = run && !any_wr && sum[CTR_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            code_q <= CODE_CYCLES;
            span_q <= 1'b0;
            smr_q  <= {SID_W{1'b1}};
        end else begin
            cnt_q <= cnt_d;
            if (wr_typ) begin
                code_q <= wdata[CODE_W-1:0];
                span_q <= wdata[SPAN_BIT];
            end
            if (wr_smr) smr_q <= wdata[SID_W-1:0];
        end
    end

    // R3: a stopped or disabled counter holds its value
    a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !any_wr) |=> $stable(cnt_q));

    // R7: stop code freezes the counter
    a_r7_stop_code: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q == CODE_STOP && !any_wr) |=> $stable(cnt_q));

    // R9: software write wins over a same-cycle increment
    a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> cnt_q[LO_W-1:0] == $past(wdata[LO_W-1:0]));

    // R10: a carry leaves a smaller value behind
    a_r10_wrap_goes_low: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> cnt_q < $past(cnt_q));
endmodule

// File: rtl/evcnt_group.sv
module evcnt_group
    import evcnt_pkg::*;
#(
    parameter int NUM_CTR       = 4,
    parameter int CTR_W         = 32,
    parameter int LANES         = 2,
    parameter int SID_W         = 16,
    parameter int ADDR_W        = 12,
    parameter bit GLOBAL_FILTER = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_req,
    input  logic                    bus_we,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [31:0]             bus_wdata,
    output logic [31:0]             bus_rdata,
    output logic                    bus_rvalid,
    input  logic [LANES-1:0]        ev_valid,
    input  logic [LANES*CODE_W-1:0] ev_code,
    input  logic [LANES*SID_W-1:0]  ev_sid,
    output logic                    irq
);
    localparam int WPC  = (CTR_W > 32) ? 2 : 1;
    localparam int WA_W = ADDR_W - 2;

    bus_state_e state_q, state_d;

    logic [WA_W-1:0]    wa;
    logic               wr_go, rd_go;
    logic [NUM_CTR-1:0] mask;
    logic [NUM_CTR-1:0] cnt_wr_lo, cnt_wr_hi, typ_wr, smr_wr;
    logic               cen_set, cen_clr, ien_set, ien_clr;
    logic               ovs_clr, ovs_set, ctl_wr, ict_wr;
    logic [NUM_CTR-1:0] cen_q, inten_q, ovs_q, wrap_vec;
    logic               run_q, irq_ctl_q;
    logic [31:0]        rd_word, rdata_q, cfg_word;
    logic               unused_top;

    logic [CTR_W-1:0]  cnt_arr  [NUM_CTR];
    logic [CODE_W-1:0] code_arr [NUM_CTR];
    logic              span_arr [NUM_CTR];
    logic [SID_W-1:0]  smr_arr  [NUM_CTR];

    assign wa         = bus_addr[ADDR_W-1:2];
    assign unused_top = ^bus_addr[1:0];
    assign wr_go      = bus_req & bus_we;
    assign rd_go      = bus_req & ~bus_we;
    assign mask       = bus_wdata[NUM_CTR-1:0];

    // ---------------- write decode ----------------
    always_comb begin
        cnt_wr_lo = '0;
        cnt_wr_hi = '0;
        typ_wr    = '0;
        smr_wr    = '0;
        for (int n = 0; n < NUM_CTR; n++) begin
            if (wr_go && int'(wa) == n*WPC)              cnt_wr_lo[n] = 1'b1;
            if (WPC == 2 && wr_go && int'(wa) == n*WPC+1) cnt_wr_hi[n] = 1'b1;
            if (wr_go && int'(wa) == WA_TYP + n)          typ_wr[n]    = 1'b1;
            if (wr_go && int'(wa) == WA_SMR + n)          smr_wr[n]    = 1'b1;
        end
        cen_set = wr_go && int'(wa) == WA_CENS;
        cen_clr = wr_go && int'(wa) == WA_CENC;
        ien_set = wr_go && int'(wa) == WA_IENS;
        ien_clr = wr_go && int'(wa) == WA_IENC;
        ovs_clr = wr_go && int'(wa) == WA_OVC;
        ovs_set = wr_go && int'(wa) == WA_OVS;
        ctl_wr  = wr_go && int'(wa) == WA_CTL;
        ict_wr  = wr_go && int'(wa) == WA_ICT;
    end

    // ---------------- counter slices ----------------
    for (genvar n = 0; n < NUM_CTR; n++) begin : g_ctr
        localparam int FSRC = GLOBAL_FILTER ? 0 : n;
        logic             eff_span;
        logic [SID_W-1:0] eff_smr;
        assign eff_span = span_arr[FSRC];
        assign eff_smr  = smr_arr[FSRC];

        evcnt_slice #(.CTR_W(CTR_W), .LANES(LANES), .SID_W(SID_W)) u_slice (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (run_q & cen_q[n]),
            .wr_lo    (cnt_wr_lo[n]),
            .wr_hi    (cnt_wr_hi[n]),
            .wr_typ   (typ_wr[n]),
            .wr_smr   (smr_wr[n]),
            .wdata    (bus_wdata),
            .eff_span (eff_span),
            .eff_smr  (eff_smr),
            .ev_valid (ev_valid),
            .ev_code  (ev_code),
            .ev_sid   (ev_sid),
            .cnt_q    (cnt_arr[n]),
            .code_q   (code_arr[n]),
            .span_q   (span_arr[n]),
            .smr_q    (smr_arr[n]),
            .wrap     (wrap_vec[n])
        );
    end

    // ---------------- group bitmaps and controls ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cen_q     <= '0;
            inten_q   <= '0;
            ovs_q     <= '0;
            run_q     <= 1'b0;
            irq_ctl_q <= 1'b0;
        end else begin
            cen_q   <= (cen_q | (cen_set ? mask : '0)) & ~(cen_clr ? mask : '0);
            inten_q <= (inten_q | (ien_set ? mask : '0)) & ~(ien_clr ? mask : '0);
            ovs_q   <= (ovs_q & ~(ovs_clr ? mask : '0)) | (ovs_set ? mask : '0) | wrap_vec;
            if (ctl_wr) run_q     <= bus_wdata[0];
            if (ict_wr) irq_ctl_q <= bus_wdata[0];
        end
    end

    assign irq = irq_ctl_q & (|(ovs_q & inten_q));

    // ---------------- read mux ----------------
    always_comb begin
        cfg_word        = '0;
        cfg_word[5:0]   = 6'(NUM_CTR - 1);
        cfg_word[13:8]  = 6'(CTR_W - 1);
        cfg_word[23]    = GLOBAL_FILTER;
    end

    always_comb begin
        logic [63:0] cnt_ext;
        rd_word = '0;
        for (int n = 0; n < NUM_CTR; n++) begin
            cnt_ext = 64'(cnt_arr[n]);
            if (int'(wa) == n*WPC)                rd_word = cnt_ext[31:0];
            if (WPC == 2 && int'(wa) == n*WPC+1)  rd_word = cnt_ext[63:32];
            if (int'(wa) == WA_TYP + n) begin
                rd_word           = 32'(code_arr[n]);
                rd_word[SPAN_BIT] = span_arr[n];
            end
            if (int'(wa) == WA_SMR + n)           rd_word = 32'(smr_arr[n]);
        end
        case (int'(wa))
            WA_CENS, WA_CENC: rd_word = 32'(cen_q);
            WA_IENS, WA_IENC: rd_word = 32'(inten_q);
            WA_OVS, WA_OVC:   rd_word = 32'(ovs_q);
            WA_CFG:           rd_word = cfg_word;
            WA_CTL:           rd_word = 32'(run_q);
            WA_ICT:           rd_word = 32'(irq_ctl_q);
            default: ;
        endcase
    end

    // ---------------- read response state machine ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: state_d = rd_go ? BUS_RESP : BUS_IDLE;
            BUS_RESP: state_d = rd_go ? BUS_RESP : BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (rd_go) rdata_q <= rd_word;
        end
    end

    always_comb begin
        bus_rvalid = (state_q == BUS_RESP);
        bus_rdata  = rdata_q;
    end

    // R12: response strobe timing
    a_r12_resp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_go |=> bus_rvalid);
    a_r12_quiet_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_go |=> !bus_rvalid);

    // R10: overflow bits persist until cleared
    a_r10_ovs_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !ovs_clr |=> ((ovs_q & $past(ovs_q)) == $past(ovs_q)));

    // R11: an enabled wrap raises the interrupt on the next cycle
    a_r11_wrap_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ctl_q && |(wrap_vec & inten_q) && !wr_go) |=> irq);
endmodule

// File: tb/evcnt_group_tb_top.sv
module evcnt_group_tb_top;
    localparam int LANES = 2;
    localparam int SID_W = 16;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 bus_req = 1'b0, bus_we = 1'b0;
    logic [11:0]          bus_addr = '0;
    logic [31:0]          bus_wdata = '0;
    logic [31:0]          rdata_i, rdata_g;
    logic                 rvalid_i, rvalid_g;
    logic                 irq_i, irq_g;
    logic [LANES-1:0]     ev_valid = '0;
    logic [LANES*16-1:0]  ev_code = '0;
    logic [LANES*SID_W-1:0] ev_sid = '0;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    evcnt_group #(.GLOBAL_FILTER(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_i),
        .bus_rvalid(rvalid_i), .ev_valid(ev_valid), .ev_code(ev_code),
        .ev_sid(ev_sid), .irq(irq_i));

    evcnt_group #(.GLOBAL_FILTER(1'b1)) dut_g (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_g),
        .bus_rvalid(rvalid_g), .ev_valid(ev_valid), .ev_code(ev_code),
        .ev_sid(ev_sid), .irq(irq_g));

    // {we, addr, wdata, expected per-counter, expected shared, requirement}
    localparam int NTBL = 17;
    localparam logic [112:0] TBL [NTBL] = '{
        {1'b0, 12'hE00, 32'h0, 32'h0000_1F03, 32'h0080_1F03, 4'd1},  // R1 config
        {1'b0, 12'h000, 32'h0, 32'h0, 32'h0, 4'd1},                  // R1 counter 0
        {1'b0, 12'hC00, 32'h0, 32'h0, 32'h0, 4'd1},                  // R1 enables
        {1'b0, 12'hCC0, 32'h0, 32'h0, 32'h0, 4'd1},                  // R1 overflow
        {1'b0, 12'hA04, 32'h0, 32'h0000_FFFF, 32'h0000_FFFF, 4'd1},  // R1 match reset
        {1'b1, 12'hC00, 32'h5, 32'h0, 32'h0, 4'd2},
        {1'b1, 12'hC00, 32'h2, 32'h0, 32'h0, 4'd2},
        {1'b0, 12'hC20, 32'h0, 32'h7, 32'h7, 4'd2},                  // R2 set ORs
        {1'b1, 12'hC20, 32'h4, 32'h0, 32'h0, 4'd2},
        {1'b0, 12'hC00, 32'h0, 32'h3, 32'h3, 4'd2},                  // R2 clear
        {1'b1, 12'hC40, 32'hF, 32'h0, 32'h0, 4'd2},
        {1'b1, 12'hC60, 32'h3, 32'h0, 32'h0, 4'd2},
        {1'b0, 12'hC40, 32'h0, 32'hC, 32'hC, 4'd2},                  // R2 irq enables
        {1'b1, 12'h400, 32'h2000_0001, 32'h0, 32'h0, 4'd5},
        {1'b0, 12'h400, 32'h0, 32'h2000_0001, 32'h2000_0001, 4'd5},  // R5 type readback
        {1'b1, 12'h00C, 32'h0000_DEAD, 32'h0, 32'h0, 4'd9},
        {1'b0, 12'h00C, 32'h0, 32'h0000_DEAD, 32'h0000_DEAD, 4'd9}   // R9 preload
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] ei,
                      input logic [31:0] eg, input string tag);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_req = 1'b0;
        chk(rdata_i == ei, {tag, " per-counter"}, rdata_i, ei);
        chk(rdata_g == eg, {tag, " shared"}, rdata_g, eg);
    endtask

    task automatic ev(input logic [15:0] c0, input logic [15:0] s0, input bit v0,
                      input logic [15:0] c1, input logic [15:0] s1, input bit v1);
        ev_code = {c1, c0}; ev_sid = {s1, s0}; ev_valid = {v1, v0};
        @(negedge clk);
        ev_valid = '0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        do_reset();
        chk(irq_i == 1'b0 && irq_g == 1'b0, "R1 irq low", 32'(irq_i), 32'h0);

        for (int i = 0; i < NTBL; i++) begin
            logic [112:0] e;
            e = TBL[i];
            if (e[112]) wr(e[111:100], e[99:68]);
            else rd(e[111:100], e[67:36], e[35:4], $sformatf("R%0d table %0d", e[3:0], i));
        end

        // R12: strobe after read / quiet after write
        rd(12'hE04, 32'h0, 32'h0, "R12 ctl read");
        chk(rvalid_i && rvalid_g, "R12 rvalid after read", 32'(rvalid_i), 32'h1);
        wr(12'hE04, 32'h0);
        chk(!rvalid_i && !rvalid_g, "R12 rvalid after write", 32'(rvalid_i), 32'h0);

        do_reset();
        wr(12'h400, 32'h1);  wr(12'hA00, 32'h42);
        wr(12'h404, 32'h2);
        wr(12'h408, 32'h1);  wr(12'hA08, 32'h42);
        wr(12'hC00, 32'h3);
        ev(16'h1, 16'h42, 1, 16'h0, 16'h0, 0);
        rd(12'h000, 32'h0, 32'h0, "R3 run bit off");
        wr(12'hE04, 32'h1);
        ev(16'h1, 16'h42, 1, 16'h1, 16'h43, 1);
        ev(16'h1, 16'h42, 1, 16'h1, 16'h42, 1);
        rd(12'h000, 32'h3, 32'h3, "R4 exact match");
        ev(16'h2, 16'h42, 1, 16'h2, 16'h42, 1);
        ev(16'h2, 16'h42, 0, 16'h2, 16'hFFFF, 1);
        rd(12'h004, 32'h1, 32'h2, "R6 shared filter");
        rd(12'h008, 32'h0, 32'h0, "R3 bit disabled");

        wr(12'h000, 32'h0); wr(12'h400, 32'h2000_0003); wr(12'hA00, 32'h41);
        ev(16'h3, 16'h40, 1, 16'h3, 16'h43, 1);
        ev(16'h3, 16'h44, 1, 16'h3, 16'h3F, 1);
        ev(16'h3, 16'h42, 1, 16'h0, 16'h0, 0);
        rd(12'h000, 32'h3, 32'h3, "R5 pattern match");
        wr(12'h004, 32'h0); wr(12'h404, 32'h2000_0002);
        ev(16'h2, 16'h1234, 1, 16'h0, 16'h0, 0);
        rd(12'h004, 32'h1, 32'h0, "R5 all-ones pattern / R6");

        wr(12'h000, 32'h0); wr(12'h400, 32'h0000_FFFF);
        ev(16'hFFFF, 16'hFFFF, 1, 16'hFFFF, 16'h41, 1);
        ev(16'hFFFF, 16'hFFFF, 1, 16'hFFFF, 16'h41, 1);
        rd(12'h000, 32'h0, 32'h0, "R7 stop code");

        wr(12'h00C, 32'h0);
        wr(12'hC00, 32'h8);
        repeat (5) @(negedge clk);
        wr(12'hC20, 32'h8);
        rd(12'h00C, 32'd6, 32'd6, "R8 cycle count");

        wr(12'h400, 32'h1); wr(12'hA00, 32'h42); wr(12'h000, 32'hFFFF_FFFE);
        ev(16'h1, 16'h42, 1, 16'h1, 16'h42, 1);
        rd(12'h000, 32'h0, 32'h0, "R10 wrapped value");
        rd(12'hCC0, 32'h1, 32'h1, "R10 overflow set");
        chk(!irq_i && !irq_g, "R11 no enables", 32'(irq_i), 32'h0);
        wr(12'hC40, 32'h1);
        chk(!irq_i && !irq_g, "R11 control off", 32'(irq_i), 32'h0);
        wr(12'hE50, 32'h1);
        chk(irq_i && irq_g, "R11 raised", 32'(irq_i), 32'h1);
        wr(12'hC60, 32'h1);
        chk(!irq_i && !irq_g, "R11 enable cleared", 32'(irq_i), 32'h0);
        wr(12'hC40, 32'h1);
        chk(irq_i && irq_g, "R11 re-enabled", 32'(irq_i), 32'h1);
        wr(12'hC80, 32'h1);
        rd(12'hCC0, 32'h0, 32'h0, "R10 overflow cleared");
        chk(!irq_i && !irq_g, "R11 after clear", 32'(irq_i), 32'h0);
        wr(12'hCC0, 32'h2);
        rd(12'hC80, 32'h2, 32'h2, "R10 overflow set by write");

        ev_code = {16'h1, 16'h1}; ev_sid = {16'h42, 16'h42}; ev_valid = 2'b11;
        wr(12'h000, 32'h100);
        ev_valid = '0;
        rd(12'h000, 32'h100, 32'h100, "R9 write beats event");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule